// File: doc/BRIEF.md
# Dithered Third-Order Cascaded Delta-Sigma Modulator

This block turns a fractional frequency word into a stream of small signed integers, one per reference clock. The stream is added to the integer part of a synthesizer's feedback divide ratio. Over time its mean equals the fractional word divided by 2^24, so the loop locks to a fractional average ratio.

Three first-order accumulators are cascaded. Each one integrates the residue of the stage before it. A noise-cancelling combiner merges their overflow carries so that the quantisation error of the first two stages is differenced away.

A pseudo-random bit from a shift register is added to the carry-in of the second and third accumulators. The first accumulator is left clean. The dither breaks the short cycles that a constant word would otherwise produce, and these cycles show up as low-frequency spurs. A synchronous reset clears the block, and an enable input freezes it.

Top module: `frac_dsm`

## Requirements
- R1: A synchronous active-high reset `rst` clears all three accumulators, the combiner history and `offset`, and reloads the dither register with its seed. It takes priority over `en`, and `offset` reads 0 on every edge while it is held.
- R2: `offset` is a two's-complement 4-bit value that always lies in the range -3 to +4.
- R3: On each enabled edge, stage 1 adds `frac_word` to its 24-bit state. Stage 2 adds the updated stage-1 state plus the dither bit, and stage 3 adds the updated stage-2 state plus the same dither bit. Each carry is the bit-24 overflow of its sum. `offset` is registered from the carries of that same edge, so with `frac_word` = 0xFFFFFF the first three outputs after reset are 0, 3, 0.
- R4: With a constant word F, the sum of the first N enabled outputs after reset lies within floor(N·F/2^24) − 1 to floor(N·F/2^24) + 2.
- R5: The dither source is a 15-bit shift register seeded with 0x0001. Each enabled edge shifts it toward the MSB and feeds bit 14 XOR bit 13 into bit 0. The dither bit used on an edge is bit 14 before that shift. The register is never all-zero.
- R6: `offset` equals c1 + (c2 − c2') + (c3 − 2·c3' + c3''), where ' marks the carry of the previous enabled edge and '' marks the carry of the edge before that.
- R7: While `en` is low and `rst` is low, the accumulators, the combiner history, the dither register and `offset` all hold their values. Resuming continues the sequence exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes all state |
| frac_word | input | 24 | Unsigned fractional control word |
| offset | output | 4 | Signed divide-ratio offset, -3 to +4 |

## Verification
The assertions assume that `rst` and `en` are synchronous levels that are stable at each rising edge. They also assume that `frac_word` is settled at every sampling edge. Neither of these is checked by the block itself. The stimulus changes every input one nanosecond after the falling edge and reads `offset` on the falling edge, so every input is sampled only at a rising edge with clean values. The word is held constant across each averaging window, because the mean bound of R4 applies only to a fixed word. Freezes are placed inside otherwise continuous runs so that the exact-sequence comparison after resume covers R7.

// File: rtl/frac_dsm.sv
module frac_dsm #(
  parameter int ACC_W = 24,
  parameter int LFSR_W = 15,
  parameter logic [LFSR_W-1:0] SEED = 15'h0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ACC_W-1:0]  frac_word,
  output logic signed [3:0] offset
);

  localparam int TAP_HI = LFSR_W - 1;
  localparam int TAP_LO = LFSR_W - 2;

  logic [ACC_W-1:0]  acc1, acc2, acc3;
  logic [ACC_W:0]    sum1, sum2, sum3;
  logic [LFSR_W-1:0] lfsr_q;
  logic              dith, c1, c2, c3;
  logic              c2_d, c3_d, c3_dd;
  logic signed [3:0] offset_nxt;

  assign dith = lfsr_q[TAP_HI];

  assign sum1 = {1'b0, acc1} + {1'b0, frac_word};
  assign sum2 = {1'b0, acc2} + {1'b0, sum1[ACC_W-1:0]} + {{ACC_W{1'b0}}, dith};
  assign sum3 = {1'b0, acc3} + {1'b0, sum2[ACC_W-1:0]} + {{ACC_W{1'b0}}, dith};

  assign c1 = sum1[ACC_W];
  assign c2 = sum2[ACC_W];
  assign c3 = sum3[ACC_W];

  assign offset_nxt = $signed({3'b000, c1})
                    + $signed({3'b000, c2}) - $signed({3'b000, c2_d})
                    + $signed({3'b000, c3}) - $signed({2'b00, c3_d, 1'b0})
                    + $signed({3'b000, c3_dd});

  always_ff @(posedge clk) begin
    if (rst) begin
      acc1   <= '0;
      acc2   <= '0;
      acc3   <= '0;
      c2_d   <= 1'b0;
      c3_d   <= 1'b0;
      c3_dd  <= 1'b0;
      lfsr_q <= SEED;
      offset <= '0;
    end else if (en) begin
      acc1   <= sum1[ACC_W-1:0];
      acc2   <= sum2[ACC_W-1:0];
      acc3   <= sum3[ACC_W-1:0];
      c2_d   <= c2;
      c3_d   <= c3;
      c3_dd  <= c3_d;
      lfsr_q <= {lfsr_q[LFSR_W-2:0], lfsr_q[TAP_HI] ^ lfsr_q[TAP_LO]};
      offset <= offset_nxt;
    end
  end

endmodule

module frac_dsm_chk #(
  parameter int LFSR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic signed [3:0] y,
  input logic [LFSR_W-1:0] lfsr
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> y == 4'sd0);

  // R2
  out_range_chk: assert property (@(posedge clk) disable iff (rst)
    (y >= -4'sd3) && (y <= 4'sd4));

  // R7
  out_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(y));

  // R7
  lfsr_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(lfsr));

  // R5
  lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);

endmodule

bind frac_dsm frac_dsm_chk #(.LFSR_W(LFSR_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .y(offset), .lfsr(lfsr_q)
);

// File: tb/frac_dsm_bench.sv
`timescale 1ns/1ps
module frac_dsm_bench;

  localparam longint MOD = 64'd16777216;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en = 1'b0;
  logic [23:0]       frac = '0;
  logic signed [3:0] y_out;

  int total = 0;
  int bad = 0;
  int msum = 0;

  typedef struct { int y; string tag; bit acc; } item_t;
  item_t sbq[$];

  longint m1, m2, m3;
  int p2, p3, pp3, my;
  logic [14:0] lf;

  always #4 clk = ~clk;

  frac_dsm u_frac_dsm (.clk(clk), .rst(rst), .en(en), .frac_word(frac), .offset(y_out));

  // monitor: pops one expected item per cycle
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        total++;
        if (int'(y_out) != it.y) begin
          bad++;
          $display("FAIL %s: offset actual=%0d expected=%0d at %0t", it.tag, int'(y_out), it.y, $time);
        end
        if (it.acc) msum += int'(y_out);
      end
    end
  end

  // driver: applies one cycle of stimulus and predicts the output
  task automatic step(input bit r, input bit e, input logic [23:0] f,
                      input string tag, input bit acc,
                      input bit use_fixed = 1'b0, input int fixed_y = 0);
    longint t;
    int k1, k2, k3, d;
    @(negedge clk); #1;
    rst = r; en = e; frac = f;
    if (r) begin
      m1 = 0; m2 = 0; m3 = 0; p2 = 0; p3 = 0; pp3 = 0; my = 0; lf = 15'h0001;
    end else if (e) begin
      d = int'(lf[14]);
      t = m1 + longint'(f);    k1 = int'(t / MOD); m1 = t % MOD;
      t = m2 + m1 + d;         k2 = int'(t / MOD); m2 = t % MOD;
      t = m3 + m2 + d;         k3 = int'(t / MOD); m3 = t % MOD;
      my = k1 + (k2 - p2) + (k3 - 2 * p3 + pp3);
      pp3 = p3; p3 = k3; p2 = k2;
      lf = {lf[13:0], lf[14] ^ lf[13]};
    end
    sbq.push_back('{use_fixed ? fixed_y : my, tag, acc && e && !r});
  endtask

  task automatic drain();
    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  // R4: long-run mean of a constant word
  task automatic mean_window(input logic [23:0] f, input int n);
    longint fl;
    step(1'b1, 1'b1, f, "R1", 1'b0);
    step(1'b1, 1'b1, f, "R1", 1'b0);
    drain();
    msum = 0;
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, f, "R5", 1'b1);
    drain();
    fl = (longint'(n) * longint'(f)) / MOD;
    total++;
    if (longint'(msum) < fl - 1 || longint'(msum) > fl + 2) begin
      bad++;
      $display("FAIL R4: sum actual=%0d expected=%0d..%0d (word %h)", msum, fl - 1, fl + 2, f);
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset holds offset at zero
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 24'hABCDEF, "R1", 1'b0);
    // R3: hand-derived first outputs for the largest word
    step(1'b0, 1'b1, 24'hFFFFFF, "R3", 1'b0, 1'b1, 0);
    step(1'b0, 1'b1, 24'hFFFFFF, "R3", 1'b0, 1'b1, 3);
    step(1'b0, 1'b1, 24'hFFFFFF, "R3", 1'b0, 1'b1, 0);
    // R6: exact combiner output over a long run
    for (int i = 0; i < 2000; i++) step(1'b0, 1'b1, 24'hFFFFFF, "R6", 1'b0);
    drain();

    mean_window(24'h000000, 16384);
    mean_window(24'h400000, 16384);
    mean_window(24'h5A5A5A, 16384);
    mean_window(24'hC00001, 16384);

    // R7: freeze in mid-run, then resume on the same trajectory
    step(1'b1, 1'b1, 24'h333333, "R1", 1'b0);
    for (int i = 0; i < 300; i++) step(1'b0, 1'b1, 24'h333333, "R6", 1'b0);
    for (int i = 0; i < 40; i++)  step(1'b0, 1'b0, 24'h333333, "R7", 1'b0);
    for (int i = 0; i < 40; i++)  step(1'b0, 1'b0, 24'h777777, "R7", 1'b0);
    for (int i = 0; i < 300; i++) step(1'b0, 1'b1, 24'h333333, "R7", 1'b0);
    // R1: reset overrides a low enable
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 24'h333333, "R1", 1'b0);
    for (int i = 0; i < 50; i++) step(1'b0, 1'b1, 24'h0F0F0F, "R5", 1'b0);
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule